// File: doc/BRIEF.md
# Add-With-Carry Execution Unit

This unit runs the 8-bit add-with-carry instructions of a small 8-bit processor core. It holds the accumulator, six general byte registers, the flag register and a 16-bit program counter. A fetch stage offers one opcode byte at a time. The unit accepts the byte when `op_ready` is high and decodes it as one of three kinds: a register-operand form, the immediate-operand form, or an unsupported code.

A register-operand instruction completes in the cycle it is accepted. The immediate form spends one more cycle. In that cycle the unit reads the byte at the program counter from memory and then advances the counter. Every instruction computes A + operand + carry, keeps the low eight bits in A, and rebuilds the flags from the values held before the update. A `done` pulse marks the last machine cycle of each instruction, and `cycles` reports the count for that instruction. A load port presets any architectural register while the unit is idle.

Top module: `adc_exec_unit`

## Requirements
- R1: An executed instruction writes (A + operand + C) mod 256 into A, where C is flag bit 4 before the instruction.
- R2: Flag bit 6, the subtract flag, is 0 after every executed instruction.
- R3: Flag bit 7, the zero flag, is 1 after an instruction exactly when the new A is 0x00.
- R4: Flag bit 4, the carry flag, is 1 exactly when A + operand + C before the instruction exceeds 0xFF.
- R5: Flag bit 5, the half-carry flag, is 1 exactly when the low nibble of A plus the low nibble of the operand plus C exceeds 0xF.
- R6: Opcodes 0x88, 0x89, 0x8A, 0x8B, 0x8C and 0x8D take B, C, D, E, H and L as the operand, and 0x8F takes A. Each completes in its accept cycle, with `done`=1 and `cycles`=1.
- R7: Opcode 0xCE takes its operand from memory. In the cycle after it is accepted, the unit drives `mem_req`=1 with `mem_addr` equal to the PC, samples `mem_rdata`, and pulses `done` with `cycles`=2. `op_ready` is 0 during that cycle.
- R8: When an 0xCE instruction completes, the PC goes up by one and wraps from 0xFFFF to 0x0000.
- R9: Bits 3..0 of the flag register always read 0.
- R10: Any other opcode, 0x8E included, raises `illegal` for its accept cycle only. It changes no register and does not raise `done`.
- R11: For opcode 0x8F, both addends are the old value of A.
- R12: The load port acts when `ld_en`=1 and no immediate instruction is pending. It writes `ld_data[7:0]` to the register that `ld_sel` selects: 0=A, 1=B, 2=C, 3=D, 4=E, 5=H, 6=L. Code 7 writes F with `ld_data[7:4]` in the top nibble. Code 8 writes the PC with all 16 bits. Codes 9..15 write nothing. While `ld_en`=1, `op_ready` is 0, so no opcode is accepted. `gpr_flat` carries B in bits [7:0], then C, D, E and H, with L in bits [47:40].
- R13: After reset, every register and the PC are 0, the unit is idle, and `done`, `illegal` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An opcode byte is offered |
| op_byte | input | 8 | Offered opcode |
| op_ready | output | 1 | Opcode is accepted this cycle if offered |
| mem_req | output | 1 | Immediate byte read this cycle |
| mem_addr | output | 16 | Read address (the PC) |
| mem_rdata | input | 8 | Byte returned in the same cycle |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel | input | 4 | Load target code |
| ld_data | input | 16 | Load value |
| reg_a | output | 8 | Accumulator |
| reg_f | output | 8 | Flag register |
| reg_pc | output | 16 | Program counter |
| gpr_flat | output | 48 | B..L packed, B lowest |
| done | output | 1 | Last machine cycle of an instruction |
| cycles | output | 2 | Machine cycles of the completing instruction |
| illegal | output | 1 | Unsupported opcode accepted |

## Verification
The assertions watch every cycle for the properties that hold on each completion: the subtract flag is clear, the zero flag agrees with A, and the carry flag agrees with the previous operands. They also check that an unsupported code leaves every register unchanged, that the PC steps by one after an immediate read, and that the immediate form always takes a second cycle. Some behaviour shows only in the bench's scenarios against its reference model: the opcode-to-register mapping, the case where the carry-in alone produces a half-carry, the self-add case, the PC wrap from 0xFFFF, and the load codes that must write nothing.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [1:0] {OPK_REG, OPK_IMM, OPK_BAD} op_kind_e;
  typedef enum logic {ST_IDLE, ST_IMM} exec_state_e;

  typedef struct packed {
    logic [7:0] sum;
    logic       z;
    logic       h;
    logic       c;
  } alu_res_t;

  function automatic alu_res_t adc8(input logic [7:0] a, input logic [7:0] b,
                                    input logic cin);
    alu_res_t   r;
    logic [4:0] lo;
    logic [8:0] full;
    lo    = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
    full  = {1'b0, a} + {1'b0, b} + {8'b0, cin};
    r.sum = full[7:0];
    r.h   = lo[4];
    r.c   = full[8];
    r.z   = (full[7:0] == 8'h00);
    return r;
  endfunction
endpackage

// File: rtl/adc_decode.sv
module adc_decode
  import adc_pkg::*;
(
  input  logic [7:0] op,
  output op_kind_e   kind,
  output logic [2:0] src
);
  always_comb begin
    src  = op[2:0];
    kind = OPK_BAD;
    if (op[7:3] == 5'b10001 && op[2:0] != 3'b110) kind = OPK_REG;
    else if (op == 8'hCE)                          kind = OPK_IMM;
  end
endmodule

// File: rtl/adc_alu.sv
module adc_alu
  import adc_pkg::*;
(
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  output logic [7:0] res,
  output logic [7:0] flags
);
  alu_res_t r;
  always_comb begin
    r     = adc8(a, b, cin);
    res   = r.sum;
    flags = '0;
    flags[FLAG_Z] = r.z;
    flags[FLAG_N] = 1'b0;
    flags[FLAG_H] = r.h;
    flags[FLAG_C] = r.c;
  end
endmodule

// File: rtl/adc_regfile.sv
module adc_regfile #(
  parameter int ADDR_W  = 16,
  parameter int NUM_GPR = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_fire,
  input  logic [3:0]             ld_sel,
  input  logic [ADDR_W-1:0]      ld_data,
  input  logic                   wr_en,
  input  logic [7:0]             wr_a,
  input  logic [7:0]             wr_f,
  input  logic                   pc_inc,
  input  logic [2:0]             src_sel,
  output logic [7:0]             a_q,
  output logic [7:0]             f_q,
  output logic [ADDR_W-1:0]      pc_q,
  output logic [8*NUM_GPR-1:0]   gpr_flat,
  output logic [7:0]             src_val
);
  localparam logic [3:0] SEL_A  = 4'd0;
  localparam logic [3:0] SEL_F  = 4'd7;
  localparam logic [3:0] SEL_PC = 4'd8;

  logic [7:0] gpr_q [NUM_GPR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      f_q  <= '0;
      pc_q <= '0;
      for (int i = 0; i < NUM_GPR; i++) gpr_q[i] <= '0;
    end else begin
      if (ld_fire && ld_sel == SEL_A) a_q <= ld_data[7:0];
      else if (wr_en)                 a_q <= wr_a;
      if (ld_fire && ld_sel == SEL_F) f_q <= {ld_data[7:4], 4'b0000};
      else if (wr_en)                 f_q <= {wr_f[7:4], 4'b0000};
      if (ld_fire && ld_sel == SEL_PC) pc_q <= ld_data;
      else if (pc_inc)                 pc_q <= pc_q + ADDR_W'(1);
      for (int i = 0; i < NUM_GPR; i++)
        if (ld_fire && ld_sel == 4'(i + 1)) gpr_q[i] <= ld_data[7:0];
    end
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_flat
    assign gpr_flat[8*g +: 8] = gpr_q[g];
  end

  always_comb begin
    src_val = '0;
    if (src_sel == 3'd7)                  src_val = a_q;
    else if (int'(src_sel) < NUM_GPR)     src_val = gpr_q[src_sel];
  end

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !ld_fire) |=> pc_q == $past(pc_q) + ADDR_W'(1));
endmodule

// File: rtl/adc_exec_unit.sv
module adc_exec_unit
  import adc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_GPR = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [7:0]           op_byte,
  output logic                 op_ready,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [7:0]           mem_rdata,
  input  logic                 ld_en,
  input  logic [3:0]           ld_sel,
  input  logic [ADDR_W-1:0]    ld_data,
  output logic [7:0]           reg_a,
  output logic [7:0]           reg_f,
  output logic [ADDR_W-1:0]    reg_pc,
  output logic [8*NUM_GPR-1:0] gpr_flat,
  output logic                 done,
  output logic [1:0]           cycles,
  output logic                 illegal
);
  exec_state_e state_q;
  op_kind_e    kind;
  logic [2:0]  src;
  logic [7:0]  src_val, operand, alu_res, alu_flags;
  logic        idle, accept, exec_reg, exec_imm, start_imm, ld_fire, wr_en;

  adc_decode u_dec (.op(op_byte), .kind(kind), .src(src));

  assign idle      = (state_q == ST_IDLE);
  assign op_ready  = idle && !ld_en;
  assign accept    = op_valid && op_ready;
  assign exec_reg  = accept && kind == OPK_REG;
  assign start_imm = accept && kind == OPK_IMM;
  assign illegal   = accept && kind == OPK_BAD;
  assign exec_imm  = !idle;
  assign ld_fire   = ld_en && idle;
  assign wr_en     = exec_reg || exec_imm;
  assign operand   = exec_imm ? mem_rdata : src_val;

  adc_alu u_alu (.a(reg_a), .b(operand), .cin(reg_f[FLAG_C]),
                 .res(alu_res), .flags(alu_flags));

  adc_regfile #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) u_rf (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_sel(ld_sel),
    .ld_data(ld_data), .wr_en(wr_en), .wr_a(alu_res), .wr_f(alu_flags),
    .pc_inc(exec_imm), .src_sel(src), .a_q(reg_a), .f_q(reg_f),
    .pc_q(reg_pc), .gpr_flat(gpr_flat), .src_val(src_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= ST_IDLE;
    else if (start_imm) state_q <= ST_IMM;
    else if (exec_imm)  state_q <= ST_IDLE;
  end

  assign done     = wr_en;
  assign cycles   = exec_imm ? 2'd2 : (exec_reg ? 2'd1 : 2'd0);
  assign mem_req  = exec_imm;
  assign mem_addr = reg_pc;

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, start_imm}));
  assert_bad_op_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(reg_a) && $stable(reg_f) && $stable(reg_pc) && $stable(gpr_flat)));
  assert_sub_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !reg_f[FLAG_N]);
  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> reg_f[FLAG_Z] == (reg_a == 8'h00));
  assert_carry_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> reg_f[FLAG_C] == (({1'b0, $past(reg_a)} + {1'b0, $past(operand)}
                               + 9'($past(reg_f[FLAG_C]))) > 9'd255));
  assert_imm_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_imm |=> (done && cycles == 2'd2 && mem_req && !op_ready));
  assert_reg_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_reg |-> (done && cycles == 2'd1 && !mem_req));
  assert_busy_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !op_ready);
endmodule

// File: tb/sim_adc_exec_unit.sv
module sim_adc_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = '0;
  logic        op_ready, mem_req, done, illegal;
  logic [15:0] mem_addr, reg_pc;
  logic [7:0]  mem_rdata, reg_a, reg_f;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [47:0] gpr_flat;
  logic [1:0]  cycles;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] adr);
    return adr[7:0] ^ adr[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  adc_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_ready(op_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .reg_a(reg_a), .reg_f(reg_f), .reg_pc(reg_pc), .gpr_flat(gpr_flat),
    .done(done), .cycles(cycles), .illegal(illegal));

  // reference model state
  int m_a = 0, m_f = 0, m_pc = 0;
  int m_g [6] = '{0, 0, 0, 0, 0, 0};
  bit m_imm = 0;
  bit m_self = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_add(input int b);
    int cin, s;
    cin = (m_f >> 4) & 1;
    s = m_a + b + cin;
    m_f = 0;
    if ((m_a % 16) + (b % 16) + cin > 15) m_f += 32;
    if (s > 255) m_f += 16;
    m_a = s % 256;
    if (m_a == 0) m_f += 128;
  endtask

  task automatic chk_state();
    chk(m_self ? "R11 A" : "R1 A", int'(reg_a), m_a);
    chk("R3 Z", int'(reg_f[7]), (m_f >> 7) & 1);
    chk("R2 N", int'(reg_f[6]), (m_f >> 6) & 1);
    chk("R5 H", int'(reg_f[5]), (m_f >> 5) & 1);
    chk("R4 C", int'(reg_f[4]), (m_f >> 4) & 1);
    chk("R9 Flow", int'(reg_f[3:0]), 0);
    chk("R8 PC", int'(reg_pc), m_pc);
    for (int i = 0; i < 6; i++) chk("R12 GPR", int'(gpr_flat[8*i +: 8]), m_g[i]);
  endtask

  task automatic cyc(input bit ov, input int op, input bit le, input int sel, input int dat);
    bit e_rdy, e_done, e_ill, e_mreq;
    int e_cyc, b;
    @(negedge clk);
    chk_state();
    op_valid = ov; op_byte = 8'(op); ld_en = le; ld_sel = 4'(sel); ld_data = 16'(dat);
    #1;
    e_rdy = !m_imm && !le; e_done = 0; e_ill = 0; e_mreq = 0; e_cyc = 0;
    m_self = 0;
    if (m_imm) begin
      e_done = 1; e_cyc = 2; e_mreq = 1;
      chk("R7 addr", int'(mem_addr), m_pc);
      model_add(int'(mem_fn(16'(m_pc))));
      m_pc = (m_pc + 1) % 65536;
      m_imm = 0;
    end else if (le) begin
      case (sel)
        0: m_a = dat % 256;
        1, 2, 3, 4, 5, 6: m_g[sel-1] = dat % 256;
        7: m_f = dat & 8'hF0;
        8: m_pc = dat % 65536;
        default: ;
      endcase
    end else if (ov) begin
      if (op == 8'hCE) m_imm = 1;
      else if (op >= 8'h88 && op <= 8'h8F && op != 8'h8E) begin
        e_done = 1; e_cyc = 1;
        b = (op == 8'h8F) ? m_a : m_g[op - 8'h88];
        m_self = (op == 8'h8F);
        model_add(b);
      end else e_ill = 1;
    end
    chk("R12 ready", int'(op_ready), int'(e_rdy));
    chk(e_cyc == 2 ? "R7 done" : "R6 done", int'(done), int'(e_done));
    chk(e_cyc == 2 ? "R7 cycles" : "R6 cycles", int'(cycles), e_cyc);
    chk("R10 illegal", int'(illegal), int'(e_ill));
    chk("R7 mem_req", int'(mem_req), int'(e_mreq));
    @(posedge clk);
  endtask

  task automatic ld(input int sel, input int dat); cyc(0, 0, 1, sel, dat); endtask
  task automatic op(input int o); cyc(1, o, 0, 0, 0); endtask
  task automatic nop(); cyc(0, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 A", int'(reg_a), 0);
    chk("R13 F", int'(reg_f), 0);
    chk("R13 PC", int'(reg_pc), 0);
    chk("R13 GPR", int'(gpr_flat != 0), 0);
    chk("R13 done", int'(done | illegal | mem_req), 0);
    rst_n = 1'b1;
    // R1/R4/R5: carry-in plus operand crossing both boundaries
    ld(0, 8'h3A); ld(1, 8'hC6); ld(7, 8'h10); op(8'h88); nop();
    // R3: zero result produced by carry-in alone
    ld(0, 8'hFF); ld(2, 8'h00); ld(7, 8'h10); op(8'h89); nop();
    // R5: half-carry from carry-in only
    ld(0, 8'h0F); ld(3, 8'h00); ld(7, 8'h10); op(8'h8A); nop();
    // R11: self add with old A
    ld(0, 8'h80); ld(7, 8'h00); op(8'h8F); nop();
    ld(0, 8'h47); op(8'h8F);
    // R6: remaining register forms
    ld(4, 8'h11); ld(5, 8'h22); ld(6, 8'hF0);
    op(8'h8B); op(8'h8C); op(8'h8D); nop();
    // R7/R8: immediate at wrap boundary, opcode held during 2nd cycle
    ld(8, 16'hFFFF); op(8'hCE); op(8'h88); nop();
    ld(8, 16'h1234); op(8'hCE); nop();
    // R10: unsupported codes
    op(8'h8E); op(8'h00); op(8'hFF); op(8'h87); op(8'h90); nop();
    // R12: load blocks opcode, codes 9..15 write nothing, F low nibble masked
    cyc(1, 8'h88, 1, 1, 8'h5C); nop();
    for (int s = 9; s < 16; s++) ld(s, 16'hBEEF);
    ld(7, 16'h00FF); nop();
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r, o;
      r = $urandom_range(0, 9);
      if (r < 3) ld($urandom_range(0, 15), $urandom_range(0, 65535));
      else if (r < 8) begin
        o = $urandom_range(0, 8);
        op(o == 8 ? 8'hCE : ((o == 6) ? 8'h8F : 8'h88 + o));
      end else if (r == 8) op($urandom_range(0, 255));
      else nop();
    end
    nop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule